// File: doc/BRIEF.md
# Privileged Trap Return Unit

This block carries out the two trap-return operations of a privileged processor core: the return from machine level and the return from supervisor level. A return request comes in with its type, the hart's current privilege level, the live machine status word and the two saved exception program counters. The unit decides whether the return is permitted and whether the return address can be fetched. If both hold, it publishes the restored program counter, the new privilege level and the rewritten status word together in one clock edge.

A rejected return publishes an exception pulse with a cause code and leaves all architectural outputs where they were. The status word that comes out of an accepted return has already been legalised. The floating-point state field is allowed only the values "off" and "dirty", and the summary-dirty bit is recomputed from the floating-point and extension state fields. The pipeline can therefore write the output straight back into its status register.

Top module: `trap_return_unit`

## Requirements
- R1: After reset the unit shows privilege 3 (machine), a zero program counter, a zero status word, cause 0, and no commit or exception pulse.
- R2: A machine-level return (retIsSret=0) is accepted only when curPriv is 3. Otherwise excValid pulses with excCause 2, and newPc, newPriv and mstatusOut keep their previous values.
- R3: A supervisor-level return (retIsSret=1) is accepted when curPriv is 1 or higher. From privilege 0 it raises excCause 2 without changing any architectural output.
- R4: An accepted return pulses retCommit for one cycle, on the clock edge that samples the request, and newPc takes mepcIn for a machine return or sepcIn for a supervisor return.
- R5: When hasCompressed is 0 and bits 1:0 of the selected return address are not both zero, a permitted return instead raises excCause 0. When hasCompressed is 1 no alignment check is made. A privilege failure takes precedence, so its cause is reported as 2.
- R6: A machine return copies status bit 7 (saved machine enable) into bit 3 (machine enable), clears bit 7, and writes 0 to bits 12:11 (saved machine level). The new privilege is the old value of bits 12:11. All other bits come from mstatusIn.
- R7: A supervisor return copies status bit 5 (saved supervisor enable) into bit 1 (supervisor enable), clears bits 5 and 8, and takes its new privilege as {0, old bit 8}.
- R8: A restored privilege value of 2 (the reserved hypervisor level) is replaced by 0 (user), so newPriv never shows 2.
- R9: In an accepted return's status word, a nonzero floating-point field (bits 14:13) becomes 3. The top bit (31) is set exactly when bits 14:13 equal 3 or bits 16:15 equal 3.
- R10: A cycle without a request leaves every output unchanged and both pulses low.
- R11: retCommit and excValid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retValid | input | 1 | Trap-return request, sampled on the rising edge |
| retIsSret | input | 1 | 1 for a supervisor return, 0 for a machine return |
| curPriv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mstatusIn | input | 32 | Live machine status word |
| mepcIn | input | 32 | Saved machine exception PC |
| sepcIn | input | 32 | Saved supervisor exception PC |
| hasCompressed | input | 1 | Compressed instructions are supported |
| newPc | output | 32 | Return address of the last accepted return |
| newPriv | output | 2 | Privilege after the last accepted return |
| mstatusOut | output | 32 | Legalised status word after the last accepted return |
| retCommit | output | 1 | One-cycle pulse: return accepted |
| excValid | output | 1 | One-cycle pulse: return rejected |
| excCause | output | 4 | Cause of the last rejection (2 illegal, 0 misaligned) |

## Verification
Every result is registered. The pulses, the cause and the three architectural outputs all change on the single rising edge that samples the request, and they hold from then until the next request. The bench drives each request on a falling edge and updates its behavioural model at that moment. It then compares every output on the following falling edge, half a cycle after the edge that carries the result. Idle cycles run through the same compare, which confirms that outputs hold. A long pseudo-random stretch mixes legal, illegal and misaligned returns back to back.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } privLevel_t;

  // status word field positions
  localparam int SIE_BIT  = 1;
  localparam int MIE_BIT  = 3;
  localparam int SPIE_BIT = 5;
  localparam int MPIE_BIT = 7;
  localparam int SPP_BIT  = 8;
  localparam int MPP_LO   = 11;
  localparam int FS_LO    = 13;
  localparam int XS_LO    = 15;

  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;

  typedef struct packed {
    logic               commit;
    logic               raiseExc;
    logic               useSret;
    logic [CAUSE_W-1:0] cause;
  } retStrobes_t;

endpackage

// File: rtl/tr_status_legalize.sv
module tr_status_legalize
  import trap_ret_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter bit FORCE_FS_DIRTY = 1'b1
) (
  input  logic [XLEN-1:0] rawStatus,
  output logic [XLEN-1:0] legalStatus
);
  localparam int SD_BIT = XLEN - 1;

  logic [1:0] fsField;

  generate
    if (FORCE_FS_DIRTY) begin : g_fsForce
      always_comb fsField = (rawStatus[FS_LO +: 2] != 2'b00) ? 2'b11 : 2'b00;
    end else begin : g_fsPass
      always_comb fsField = rawStatus[FS_LO +: 2];
    end
  endgenerate

  always_comb begin
    legalStatus               = rawStatus;
    legalStatus[FS_LO +: 2]   = fsField;
    legalStatus[SD_BIT]       = (fsField == 2'b11) || (rawStatus[XS_LO +: 2] == 2'b11);
  end

endmodule

// File: rtl/tr_ctrl.sv
module tr_ctrl
  import trap_ret_pkg::*;
(
  input  logic        retValid,
  input  logic        retIsSret,
  input  privLevel_t  curPriv,
  input  logic [1:0]  targetLow,
  input  logic        hasCompressed,
  output retStrobes_t strobes
);
  logic privOk;
  logic misaligned;

  always_comb begin
    privOk     = retIsSret ? (curPriv >= PRIV_S) : (curPriv == PRIV_M);
    misaligned = !hasCompressed && (targetLow != 2'b00);

    strobes.useSret  = retIsSret;
    strobes.commit   = retValid && privOk && !misaligned;
    strobes.raiseExc = retValid && (!privOk || misaligned);
    strobes.cause    = privOk ? CAUSE_MISALIGN : CAUSE_ILLEGAL;
  end

endmodule

// File: rtl/tr_datapath.sv
module tr_datapath
  import trap_ret_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter bit FORCE_FS_DIRTY = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  retStrobes_t        strobes,
  input  logic [XLEN-1:0]    mstatusIn,
  input  logic [XLEN-1:0]    mepcIn,
  input  logic [XLEN-1:0]    sepcIn,
  output logic [XLEN-1:0]    retTarget,
  output logic [XLEN-1:0]    pcQ,
  output privLevel_t         privQ,
  output logic [XLEN-1:0]    statusQ,
  output logic               doneQ,
  output logic               excQ,
  output logic [CAUSE_W-1:0] causeQ
);
  localparam int SD_BIT = XLEN - 1;

  logic [XLEN-1:0] stagedStatus;
  logic [XLEN-1:0] legalStatus;
  privLevel_t      rawPriv;
  privLevel_t      nextPriv;

  always_comb begin
    retTarget    = strobes.useSret ? sepcIn : mepcIn;
    stagedStatus = mstatusIn;
    if (strobes.useSret) begin
      rawPriv                  = privLevel_t'({1'b0, mstatusIn[SPP_BIT]});
      stagedStatus[SIE_BIT]    = mstatusIn[SPIE_BIT];
      stagedStatus[SPIE_BIT]   = 1'b0;
      stagedStatus[SPP_BIT]    = 1'b0;
    end else begin
      rawPriv                  = privLevel_t'(mstatusIn[MPP_LO +: 2]);
      stagedStatus[MIE_BIT]    = mstatusIn[MPIE_BIT];
      stagedStatus[MPIE_BIT]   = 1'b0;
      stagedStatus[MPP_LO +: 2] = 2'b00;
    end
    nextPriv = (rawPriv == PRIV_H) ? PRIV_U : rawPriv;
  end

  tr_status_legalize #(
    .XLEN           (XLEN),
    .FORCE_FS_DIRTY (FORCE_FS_DIRTY)
  ) uLegal (
    .rawStatus   (stagedStatus),
    .legalStatus (legalStatus)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= '0;
      privQ   <= PRIV_M;
      statusQ <= '0;
      doneQ   <= 1'b0;
      excQ    <= 1'b0;
      causeQ  <= '0;
    end else begin
      doneQ <= strobes.commit;
      excQ  <= strobes.raiseExc;
      if (strobes.raiseExc) causeQ <= strobes.cause;
      if (strobes.commit) begin
        pcQ     <= retTarget;
        privQ   <= nextPriv;
        statusQ <= legalStatus;
      end
    end
  end

  AST_EXC_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    excQ |-> ($stable(pcQ) && $stable(privQ) && $stable(statusQ))) else $error("AST_EXC_KEEPS_STATE"); // R2

  AST_NO_HYP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    privQ != PRIV_H) else $error("AST_NO_HYP_LEVEL"); // R8

  AST_SD_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (statusQ[SD_BIT] == ((statusQ[FS_LO +: 2] == 2'b11) || (statusQ[XS_LO +: 2] == 2'b11))))
    else $error("AST_SD_SUMMARY"); // R9

  AST_MRET_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !$past(strobes.useSret)) |->
      (statusQ[MIE_BIT] == $past(mstatusIn[MPIE_BIT]) && !statusQ[MPIE_BIT] && statusQ[MPP_LO +: 2] == 2'b00))
    else $error("AST_MRET_ENABLE"); // R6

  AST_SRET_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && $past(strobes.useSret)) |->
      (statusQ[SIE_BIT] == $past(mstatusIn[SPIE_BIT]) && !statusQ[SPIE_BIT] && !statusQ[SPP_BIT]))
    else $error("AST_SRET_ENABLE"); // R7

  generate
    if (FORCE_FS_DIRTY) begin : g_fsCheck
      AST_FS_OFF_OR_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
        doneQ |-> (statusQ[FS_LO +: 2] == 2'b00 || statusQ[FS_LO +: 2] == 2'b11))
        else $error("AST_FS_OFF_OR_DIRTY"); // R9
    end
  endgenerate

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_ret_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter bit FORCE_FS_DIRTY = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               retValid,
  input  logic               retIsSret,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    mstatusIn,
  input  logic [XLEN-1:0]    mepcIn,
  input  logic [XLEN-1:0]    sepcIn,
  input  logic               hasCompressed,
  output logic [XLEN-1:0]    newPc,
  output logic [1:0]         newPriv,
  output logic [XLEN-1:0]    mstatusOut,
  output logic               retCommit,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause
);
  retStrobes_t     strobes;
  logic [XLEN-1:0] retTarget;
  privLevel_t      privQ;

  tr_ctrl uCtrl (
    .retValid      (retValid),
    .retIsSret     (retIsSret),
    .curPriv       (privLevel_t'(curPriv)),
    .targetLow     (retTarget[1:0]),
    .hasCompressed (hasCompressed),
    .strobes       (strobes)
  );

  tr_datapath #(
    .XLEN           (XLEN),
    .FORCE_FS_DIRTY (FORCE_FS_DIRTY)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .mstatusIn (mstatusIn),
    .mepcIn    (mepcIn),
    .sepcIn    (sepcIn),
    .retTarget (retTarget),
    .pcQ       (newPc),
    .privQ     (privQ),
    .statusQ   (mstatusOut),
    .doneQ     (retCommit),
    .excQ      (excValid),
    .causeQ    (excCause)
  );

  assign newPriv = privQ;

  AST_MRET_NEEDS_M: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !retIsSret && curPriv != 2'd3) |=> (excValid && excCause == CAUSE_ILLEGAL))
    else $error("AST_MRET_NEEDS_M"); // R2

  AST_SRET_FROM_USER: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && retIsSret && curPriv == 2'd0) |=> (excValid && excCause == CAUSE_ILLEGAL))
    else $error("AST_SRET_FROM_USER"); // R3

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(retCommit && excValid)) else $error("AST_SINGLE_OUTCOME"); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !retValid |=> (!retCommit && !excValid && $stable(newPc) && $stable(mstatusOut)))
    else $error("AST_IDLE_QUIET"); // R10

endmodule

// File: tb/sim_trap_return_unit.sv
`timescale 1ns/1ps
module sim_trap_return_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retValid = 1'b0;
  logic        retIsSret = 1'b0;
  logic [1:0]  curPriv = 2'd0;
  logic [31:0] mstatusIn = '0;
  logic [31:0] mepcIn = '0;
  logic [31:0] sepcIn = '0;
  logic        hasCompressed = 1'b0;
  logic [31:0] newPc;
  logic [1:0]  newPriv;
  logic [31:0] mstatusOut;
  logic        retCommit;
  logic        excValid;
  logic [3:0]  excCause;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  logic [31:0] expPc = '0;
  logic [1:0]  expPriv = 2'd3;
  logic [31:0] expStatus = '0;
  logic        expDone = 1'b0;
  logic        expExc = 1'b0;
  logic [3:0]  expCause = '0;
  logic [31:0] seed = 32'h1badf00d;

  always #2 clk = ~clk;

  trap_return_unit u0 (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retIsSret(retIsSret),
    .curPriv(curPriv), .mstatusIn(mstatusIn), .mepcIn(mepcIn), .sepcIn(sepcIn),
    .hasCompressed(hasCompressed), .newPc(newPc), .newPriv(newPriv),
    .mstatusOut(mstatusOut), .retCommit(retCommit), .excValid(excValid),
    .excCause(excCause)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "newPc", newPc, expPc);
    check(tag, "newPriv", {30'd0, newPriv}, {30'd0, expPriv});
    check(tag, "mstatusOut", mstatusOut, expStatus);
    check(tag, "retCommit", {31'd0, retCommit}, {31'd0, expDone});
    check(tag, "excValid", {31'd0, excValid}, {31'd0, expExc});
    check(tag, "excCause", {28'd0, excCause}, {28'd0, expCause});
    check("R11", "exclusive pulses", {31'd0, retCommit & excValid}, 32'd0);
  endtask

  // behavioural model of one request, evaluated when the inputs are driven
  task automatic modelStep(input logic v, input logic s, input logic [1:0] p,
                           input logic [31:0] st, input logic [31:0] me,
                           input logic [31:0] se, input logic c);
    logic [31:0] tgt;
    logic [31:0] ns;
    logic [1:0]  np;
    bit allowed;
    expDone = 1'b0;
    expExc  = 1'b0;
    if (v) begin
      allowed = s ? (p != 2'd0) : (p == 2'd3);
      tgt = s ? se : me;
      if (!allowed) begin
        expExc = 1'b1; expCause = 4'd2;
      end else if (!c && tgt[1:0] != 2'b00) begin
        expExc = 1'b1; expCause = 4'd0;
      end else begin
        ns = st;
        if (s) begin
          np = {1'b0, st[8]};
          ns[1] = st[5]; ns[5] = 1'b0; ns[8] = 1'b0;
        end else begin
          np = st[12:11];
          ns[3] = st[7]; ns[7] = 1'b0; ns[12:11] = 2'b00;
        end
        if (np == 2'd2) np = 2'd0;
        if (ns[14:13] != 2'b00) ns[14:13] = 2'b11;
        ns[31] = (ns[14:13] == 2'b11) || (ns[16:15] == 2'b11);
        expDone = 1'b1;
        expPc = tgt; expPriv = np; expStatus = ns;
      end
    end
  endtask

  // called on a falling edge; compares on the next falling edge
  task automatic req(input string tag, input logic v, input logic s, input logic [1:0] p,
                     input logic [31:0] st, input logic [31:0] me,
                     input logic [31:0] se, input logic c);
    retValid = v; retIsSret = s; curPriv = p; mstatusIn = st;
    mepcIn = me; sepcIn = se; hasCompressed = c;
    modelStep(v, s, p, st, me, se, c);
    @(negedge clk);
    compareAll(tag);
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R6 + R4: machine return, saved level S, saved enable 1
    req("R6", 1, 0, 2'd3, 32'h0000_0880, 32'h0000_1000, 32'h0000_2000, 0);
    // R10: idle cycles hold
    req("R10", 0, 0, 2'd3, 32'hffff_ffff, 32'h0000_3333, 32'h0000_4444, 0);
    req("R10", 0, 1, 2'd0, 32'h0, 32'h0, 32'h0, 1);
    // R8: saved level 2 becomes user
    req("R8", 1, 0, 2'd3, 32'h0000_1000, 32'h0000_1004, 32'h0, 0);
    // R6: saved level M, enable 0, other bits kept
    req("R6", 1, 0, 2'd3, 32'h0000_1808, 32'h0000_2008, 32'h0, 0);
    // R2: machine return from S and from U, state held
    req("R2", 1, 0, 2'd1, 32'h0000_0080, 32'h0000_5000, 32'h0, 0);
    req("R2", 1, 0, 2'd0, 32'h0000_0080, 32'h0000_5000, 32'h0, 0);
    // R3: supervisor return from U is illegal
    req("R3", 1, 1, 2'd0, 32'h0000_0120, 32'h0, 32'h0000_6000, 0);
    // R7 + R4: supervisor return from S, saved level S
    req("R7", 1, 1, 2'd1, 32'h0000_0120, 32'h0, 32'h0000_6000, 0);
    // R3: supervisor return from M allowed, saved level U
    req("R3", 1, 1, 2'd3, 32'h0000_0020, 32'h0, 32'h0000_6100, 0);
    // R5: misaligned without compressed support
    req("R5", 1, 0, 2'd3, 32'h0, 32'h0000_7002, 32'h0, 0);
    req("R5", 1, 1, 2'd1, 32'h0, 32'h0, 32'h0000_7001, 0);
    // R5: same address accepted with compressed support
    req("R5", 1, 0, 2'd3, 32'h0, 32'h0000_7002, 32'h0, 1);
    // R5: illegal takes precedence over misaligned
    req("R5", 1, 0, 2'd1, 32'h0, 32'h0000_7003, 32'h0, 0);
    // R9: FS 01 forced to 11, SD set
    req("R9", 1, 0, 2'd3, 32'h0000_2000, 32'h0000_8000, 32'h0, 0);
    // R9: FS 00, XS 11 -> SD set
    req("R9", 1, 0, 2'd3, 32'h0001_8000, 32'h0000_8004, 32'h0, 0);
    // R9: stale SD in input cleared
    req("R9", 1, 1, 2'd3, 32'h8000_0000, 32'h0, 32'h0000_8008, 0);
    // R9: FS 10 forced to 11
    req("R9", 1, 1, 2'd1, 32'h0000_4000, 32'h0, 32'h0000_800c, 0);

    // R4: pseudo-random mix, back to back
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, d, e;
      seed = nextRand(seed); a = seed;
      seed = nextRand(seed); b = seed;
      seed = nextRand(seed); d = seed;
      seed = nextRand(seed); e = seed;
      req("R4", (e[3:0] != 4'd0), e[4], e[6:5], a, b, d, e[7]);
    end

    req("R10", 0, 0, 2'd0, 32'h0, 32'h0, 32'h0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule